// File: doc/BRIEF.md
# Chip-Select Wait-State Bus Controller

This block is the master side of a local memory bus. A CPU request carries an address, a read/write flag and write data. The controller compares the address with eight programmable windows and drives the chip select of the window that matches. It then times the access on the external pins and returns a one-cycle done pulse. For a read, the done pulse comes with the captured data. An address that falls in no window returns done with an error flag.

Each window has two configuration words. The base word holds the base address and a valid bit. The option word holds an address mask, a 4-bit wait count, an acknowledge-mode bit and a strobe-setup bit. In counted mode an access lasts a fixed 2 to 17 clocks. In acknowledge mode the access stays open until the peripheral pulls the active-low acknowledge input low. This suits peripherals whose latency is unknown or longer than the counted maximum.

Configuration word layout, with `cfg_sel` = 0 for the base word and 1 for the option word:
- Base word: bits [31:16] hold the base address and bit 0 is the valid bit.
- Option word: bits [31:16] hold the mask, bits [3:0] the wait count, bit 4 selects acknowledge mode and bit 5 is strobe setup.

Top module: `csw_bus_ctrl`

## Requirements
- R1: After reset, every chip select, `bus_oe_n` and `bus_we_n` are high and `cpu_done` is low. Every window is invalid, so any access before configuration completes with `cpu_err`.
- R2: A window matches when its valid bit is set and (address AND mask) equals (base AND mask). Only chip select i of window i is driven low, and `bus_addr` carries the request address for the whole access.
- R3: When several windows match, the lowest-numbered window is selected.
- R4: An address that matches no valid window drives no chip select. It raises `cpu_done` together with `cpu_err` in the cycle after the request is accepted.
- R5: In counted mode with wait count W, the chip select is low for exactly W+2 cycles. `cpu_done` is high for one cycle, in the first cycle after the chip select returns high.
- R6: In acknowledge mode, the access ends at the first clock edge at which `bus_ta_n` is sampled low. If `bus_ta_n` is low during the k-th chip-select cycle, the chip select is low for exactly k cycles, and the wait count is ignored.
- R7: A read drives `bus_oe_n` low and keeps `bus_we_n` high. A write drives `bus_we_n` low, keeps `bus_oe_n` high and drives `bus_wdata`. Neither strobe is low while no chip select is low.
- R8: With strobe setup clear, the strobe is low from the first chip-select cycle. With it set, the strobe goes low from the second chip-select cycle. An access that lasts one cycle then has no strobe.
- R9: For a read, `bus_rdata` sampled at the completing edge appears on `cpu_rdata` during the done cycle.
- R10: After a done cycle, chip selects stay high for at least one more cycle before the next access can start. A request is accepted only in the idle state.
- R11: In counted mode, `bus_ta_n` has no effect on the access length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, sampled only when idle |
| cpu_addr | input | 16 | Access address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with done |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Unmapped-address flag, valid with done |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = base word, 1 = option word |
| cfg_idx | input | 3 | Window number |
| cfg_wdata | input | 32 | Configuration word |
| bus_cs_n | output | 8 | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ta_n | input | 1 | Active-low transfer acknowledge |

## Verification
A request presented while idle is accepted at the next edge, and from that edge the chip select, strobes and bus address are visible. The chip select stays low for W+2 cycles, or k cycles in acknowledge mode. Done, error and read data then follow one cycle after the completing edge, and an unmapped address gives done and error in the first cycle after acceptance. The bench samples every output at the falling edge and counts chip-select cycles from acceptance to the done pulse. It checks each strobe level against the cycle number, checks the completion data and flags in the done cycle, and confirms the idle cycle that follows.

// File: rtl/csw_bus_ctrl.sv
module csw_bus_ctrl #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int NCS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic [AW-1:0]          cpu_addr,
  input  logic                   cpu_we,
  input  logic [DW-1:0]          cpu_wdata,
  output logic [DW-1:0]          cpu_rdata,
  output logic                   cpu_done,
  output logic                   cpu_err,
  input  logic                   cfg_we,
  input  logic                   cfg_sel,
  input  logic [$clog2(NCS)-1:0] cfg_idx,
  input  logic [16+AW-1:0]       cfg_wdata,
  output logic [NCS-1:0]         bus_cs_n,
  output logic                   bus_oe_n,
  output logic                   bus_we_n,
  output logic [AW-1:0]          bus_addr,
  output logic [DW-1:0]          bus_wdata,
  input  logic [DW-1:0]          bus_rdata,
  input  logic                   bus_ta_n
);
  localparam int IW  = $clog2(NCS);
  localparam int FLD = 16;
  localparam int WCW = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_DONE} st_t;

  logic [AW-1:0]  base_a  [NCS];
  logic [AW-1:0]  mask_a  [NCS];
  logic [WCW-1:0] wait_a  [NCS];
  logic           vld_a   [NCS];
  logic           ext_a   [NCS];
  logic           setup_a [NCS];

  st_t           st;
  logic [WCW:0]  cnt;
  logic          ext_q, we_q;
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic          fin;
  logic          in_acc;
  wire           unused_cfg = ^cfg_wdata[FLD-1:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCS; i++) begin
        base_a[i]  <= '0;
        mask_a[i]  <= '0;
        wait_a[i]  <= '0;
        vld_a[i]   <= 1'b0;
        ext_a[i]   <= 1'b0;
        setup_a[i] <= 1'b0;
      end
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        base_a[cfg_idx] <= cfg_wdata[FLD +: AW];
        vld_a[cfg_idx]  <= cfg_wdata[0];
      end else begin
        mask_a[cfg_idx]  <= cfg_wdata[FLD +: AW];
        wait_a[cfg_idx]  <= cfg_wdata[WCW-1:0];
        ext_a[cfg_idx]   <= cfg_wdata[4];
        setup_a[cfg_idx] <= cfg_wdata[5];
      end
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (vld_a[i] && ((cpu_addr & mask_a[i]) == (base_a[i] & mask_a[i]))) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign fin    = ext_q ? !bus_ta_n : (cnt == '0);
  assign in_acc = (st == ST_ACC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      ext_q     <= 1'b0;
      we_q      <= 1'b0;
      bus_cs_n  <= '1;
      bus_oe_n  <= 1'b1;
      bus_we_n  <= 1'b1;
      bus_addr  <= '0;
      bus_wdata <= '0;
      cpu_rdata <= '0;
      cpu_done  <= 1'b0;
      cpu_err   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          cpu_done <= 1'b0;
          cpu_err  <= 1'b0;
          if (cpu_req) begin
            if (hit) begin
              st        <= ST_ACC;
              bus_cs_n  <= ~(NCS'(1) << hit_idx);
              bus_addr  <= cpu_addr;
              bus_wdata <= cpu_wdata;
              we_q      <= cpu_we;
              ext_q     <= ext_a[hit_idx];
              cnt       <= {1'b0, wait_a[hit_idx]} + 1'b1;
              bus_oe_n  <= setup_a[hit_idx] | cpu_we;
              bus_we_n  <= setup_a[hit_idx] | ~cpu_we;
            end else begin
              st       <= ST_DONE;
              cpu_done <= 1'b1;
              cpu_err  <= 1'b1;
            end
          end
        end
        ST_ACC: begin
          if (fin) begin
            st        <= ST_DONE;
            bus_cs_n  <= '1;
            bus_oe_n  <= 1'b1;
            bus_we_n  <= 1'b1;
            cpu_rdata <= bus_rdata;
            cpu_done  <= 1'b1;
            cpu_err   <= 1'b0;
          end else begin
            cnt      <= cnt - 1'b1;
            bus_oe_n <= we_q;
            bus_we_n <= ~we_q;
          end
        end
        default: begin
          st       <= ST_IDLE;
          cpu_done <= 1'b0;
          cpu_err  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/csw_bus_ctrl_chk.sv
module csw_bus_ctrl_chk #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cs_n,
  input logic           oe_n,
  input logic           we_n,
  input logic           done,
  input logic           err,
  input logic           in_acc,
  input logic           ext_q,
  input logic           ta_n
);
  p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_err_no_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (&cs_n && $past(&cs_n)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ack_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && ext_q && !ta_n) |=> (done && &cs_n));

  p_strobe_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !(&cs_n));

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_idle_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> &cs_n);
endmodule

bind csw_bus_ctrl csw_bus_ctrl_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
  .done(cpu_done), .err(cpu_err), .in_acc(in_acc), .ext_q(ext_q), .ta_n(bus_ta_n)
);

// File: tb/csw_bus_ctrl_bench.sv
module csw_bus_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_done, cpu_err;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  bus_cs_n;
  logic        bus_oe_n, bus_we_n;
  logic [15:0] bus_addr, bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ta_n = 1'b1;

  int checks = 0;
  int errs = 0;
  int cyc_total = 0;

  logic [15:0] m_base [8];
  logic [15:0] m_mask [8];
  logic        m_vld  [8];
  logic [5:0]  m_opt  [8];

  csw_bus_ctrl u_csw_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_done(cpu_done), .cpu_err(cpu_err), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .bus_cs_n(bus_cs_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ta_n(bus_ta_n)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc_total);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int decode(input logic [15:0] a);
    for (int i = 0; i < 8; i++)
      if (m_vld[i] && ((a & m_mask[i]) == (m_base[i] & m_mask[i]))) return i;
    return 8;
  endfunction

  task automatic cfg(input int idx, input logic [15:0] base, input logic vld,
                     input logic [15:0] mask, input logic [5:0] opt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = 3'(idx); cfg_wdata = {base, 15'd0, vld};
    @(negedge clk);
    cfg_sel = 1'b1; cfg_wdata = {mask, 10'd0, opt};
    @(negedge clk);
    cfg_we = 1'b0;
    m_base[idx] = base; m_vld[idx] = vld; m_mask[idx] = mask; m_opt[idx] = opt;
  endtask

  task automatic do_acc(input logic [15:0] a, input logic w, input logic [15:0] wd,
                        input logic [15:0] rd, input int k, input string tag);
    int ei, cyc, n, exp_len, cs_bad, strb_bad;
    logic setup, ext;
    bit act;
    ei = decode(a);
    setup = 1'b0; ext = 1'b0; exp_len = 0;
    if (ei < 8) begin
      setup = m_opt[ei][5];
      ext   = m_opt[ei][4];
      exp_len = ext ? k : int'(m_opt[ei][3:0]) + 2;
    end
    cpu_req = 1'b1; cpu_addr = a; cpu_we = w; cpu_wdata = wd; bus_rdata = rd; bus_ta_n = 1'b1;
    cyc = 0; n = 0; cs_bad = 0; strb_bad = 0;
    while (n < 200) begin
      @(negedge clk);
      n++;
      cpu_req = 1'b0;
      if (cpu_done) break;
      if (bus_cs_n != 8'hFF) begin
        cyc++;
        if (ei >= 8 || bus_cs_n != ~(8'b1 << ei)) cs_bad++;
        act = !setup || cyc >= 2;
        if (bus_oe_n != !(act && !w) || bus_we_n != !(act && w) ||
            bus_addr != a || (w && bus_wdata != wd)) strb_bad++;
      end else cs_bad++;
      if (ext) bus_ta_n = !(cyc == k);
      else     bus_ta_n = 1'($urandom_range(0, 1));
    end
    bus_ta_n = 1'b1;
    chk(cpu_done, {tag, " R5 done seen"}, int'(cpu_done), 1);
    chk(cpu_err == (ei >= 8), {tag, " R4 err flag"}, int'(cpu_err), int'(ei >= 8));
    chk(cyc == exp_len, {tag, ext ? " R6 cs length" : " R5 R11 cs length"}, cyc, exp_len);
    chk(cs_bad == 0, {tag, " R2 R3 select"}, cs_bad, 0);
    chk(strb_bad == 0, {tag, " R7 R8 strobes"}, strb_bad, 0);
    chk(bus_cs_n == 8'hFF, {tag, " R5 cs high at done"}, int'(bus_cs_n), 'hFF);
    if (ei < 8 && !w) chk(cpu_rdata == rd, {tag, " R9 read data"}, int'(cpu_rdata), int'(rd));
    @(negedge clk);
    chk(!cpu_done && bus_cs_n == 8'hFF, {tag, " R10 idle gap"},
        int'({cpu_done, bus_cs_n}), 'hFF);
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_mask[i] = '0; m_vld[i] = 1'b0; m_opt[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(bus_cs_n == 8'hFF && bus_oe_n && bus_we_n && !cpu_done, "R1 reset outputs",
        int'({cpu_done, bus_oe_n, bus_we_n, bus_cs_n}), 'h3FF);
    rst_n = 1'b1;
    @(negedge clk);
    do_acc(16'h1234, 1'b0, 16'h0, 16'hBEEF, 1, "R1 unconfigured");

    cfg(2, 16'h1000, 1'b1, 16'hF000, 6'h00);
    cfg(5, 16'h1200, 1'b1, 16'hFF00, 6'h0F);
    cfg(6, 16'h3200, 1'b1, 16'hFF00, 6'h0F);
    cfg(3, 16'h4000, 1'b1, 16'hF000, 6'h37);
    cfg(7, 16'h5000, 1'b1, 16'hF000, 6'h23);
    cfg(0, 16'h2000, 1'b0, 16'hF000, 6'h00);

    do_acc(16'h1234, 1'b0, 16'h0, 16'hA5A5, 1, "R3 overlap low wins");
    do_acc(16'h1234, 1'b1, 16'h5A5A, 16'h0, 1, "R2 W=0 write");
    do_acc(16'h3210, 1'b0, 16'h0, 16'h1357, 1, "R5 W=15 read");
    do_acc(16'h2000, 1'b0, 16'h0, 16'h0, 1, "R4 invalid window");
    do_acc(16'h9000, 1'b1, 16'h1, 16'h0, 1, "R4 unmapped");
    do_acc(16'h4004, 1'b0, 16'h0, 16'hC0DE, 1, "R6 ack k=1");
    do_acc(16'h4008, 1'b1, 16'h7777, 16'h0, 20, "R6 ack k=20");
    do_acc(16'h400C, 1'b0, 16'h0, 16'h2468, 2, "R8 ack k=2 setup");
    do_acc(16'h5010, 1'b0, 16'h0, 16'hFACE, 1, "R8 setup W=3 read");
    do_acc(16'h5010, 1'b1, 16'h3C3C, 16'h0, 1, "R8 setup W=3 write");

    for (int i = 0; i < 8; i++) begin
      logic [15:0] mk;
      case ($urandom_range(0, 3))
        0: mk = 16'hF000;
        1: mk = 16'hFF00;
        2: mk = 16'hFFF0;
        default: mk = 16'hE000;
      endcase
      cfg(i, 16'($urandom), $urandom_range(0, 3) != 0, mk, 6'($urandom));
    end
    for (int t = 0; t < 150; t++) begin
      logic [15:0] a;
      if ($urandom_range(0, 3) != 0) a = m_base[$urandom_range(0, 7)] ^ 16'($urandom_range(0, 15));
      else a = 16'($urandom);
      do_acc(a, 1'($urandom), 16'($urandom), 16'($urandom), $urandom_range(1, 25), "R2 random");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule